// File: doc/BRIEF.md
# Factory calibration word generator

This block turns factory-test fuse data into per-sensor calibration words for a thermal sensing array of up to four sensors. It takes four 16-bit fuse halfwords holding the ambient temperature at factory test and one raw code per sensor. For each sensor it converts the code to a temperature with a linear model. It then derives a 12-bit correction word centred on 0x800 and writes that word into a packed bank of 32-bit calibration registers, two sensors to a register.

A one-cycle start pulse launches a run. Sensors are handled one at a time in ascending index order, and each sensor's two divisions share one iterative divider. Every write appears on the ports with its register index, data and byte enables. The bank updates from those same writes. A sensor whose correction does not fit 12 bits is skipped and its field stays as it was. A legacy mode copies raw codes into the fields with no arithmetic. A single-cycle done pulse closes every run, including an aborted one.

Top module: `fuse_cal_gen`

## Requirements
- R1: After reset every present calibration field reads 0x800, field bits outside the 12-bit fields read zero, and busy, done, abort_err, sensor_ok and sensor_skip are all zero.
- R2: Halfword k is fuse_words[16k+15:16k]. The factory temperature is halfword 0 bits [11:0] times 100 (millidegrees). Sensors 0 to 2 use bits [11:0] of halfwords 1 to 3. Sensor 3 uses {hw3[15:12], hw2[15:12], hw1[15:12]}.
- R3: With sensor temperature T = T_OFFSET - floor(code*T_SCALE/10), the calibration word is 0x800 - trunc((T - factory)*10 / T_SCALE), where the division truncates toward zero.
- R4: A word outside 0..4095 is not written and the sensor's field keeps its old value. The sensor's sensor_skip bit is set instead of its sensor_ok bit, the two are never both set, and the remaining sensors are still processed.
- R5: Sensor i is written to register i/2. An even i goes to bits [11:0] with wr_be = 4'b0011, and an odd i goes to bits [27:16] with wr_be = 4'b1100. All other data bits of a write are zero.
- R6: If halfword 0 is all zero, the run ends with abort_err set, no write and all fields unchanged.
- R7: With legacy_mode high and fuse_bytes >= 2*SENSORS, sensor i's field receives halfword i bits [11:0] unchanged. With fewer bytes the run aborts as in R6.
- R8: After a start in idle, busy stays high and writes occur in ascending sensor order, at most one per sensor. A one-cycle done pulse ends the run, and by then cal_regs holds the final values.
- R9: A start pulse while busy (including the done cycle) is ignored. The running job and its captured inputs are unaffected.
- R10: sensor_ok, sensor_skip and abort_err are cleared when a run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse, accepted only when idle |
| legacy_mode | input | 1 | 1: copy raw codes, 0: compute corrections |
| fuse_words | input | 64 | Four fuse halfwords, halfword 0 in the low bits |
| fuse_bytes | input | 8 | Number of valid fuse bytes (legacy length check) |
| busy | output | 1 | High from acceptance of start through the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| abort_err | output | 1 | Last run aborted without writing |
| wr_en | output | 1 | Calibration register write strobe |
| wr_index | output | WR_IDX_W | Register index of the write |
| wr_data | output | 32 | Write data, field in place |
| wr_be | output | 4 | Byte enables of the write |
| cal_regs | output | 32*NREG | Packed calibration registers, register 0 in the low bits |
| sensor_ok | output | SENSORS | Sensor field written in the last run |
| sensor_skip | output | SENSORS | Sensor skipped as out of range in the last run |

## Verification
Two events can land in the same cycle: a new start request and the done pulse of the running job. The bench drives start together with fresh fuse data in exactly the cycle where it sees done. It then confirms that busy falls and stays low, that no write follows, and that the registers still hold the first run's results. A start issued in mid-run with different data and mode is judged the same way, against expected values computed only from the first request.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

   localparam int HALF_W    = 16;
   localparam int NUM_HALF  = 4;
   localparam int FUSE_W    = HALF_W * NUM_HALF;
   localparam int FIELD_W   = 12;
   localparam int REG_W     = 32;
   localparam int MID_CODE  = 2048;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_LEGACY,
      ST_FETCH,
      ST_DIV_T,
      ST_DIV_C,
      ST_WRITE,
      ST_FIN
   } fcg_state_e;

   // Factory code of one sensor; sensor 3 is gathered from top nibbles
   function automatic logic [FIELD_W-1:0] sensor_code(input logic [FUSE_W-1:0] hw,
                                                       input logic [1:0] idx);
      logic [FIELD_W-1:0] c;
      case (idx)
         2'd0:    c = hw[1*HALF_W +: FIELD_W];
         2'd1:    c = hw[2*HALF_W +: FIELD_W];
         2'd2:    c = hw[3*HALF_W +: FIELD_W];
         default: c = {hw[4*HALF_W-1 -: 4], hw[3*HALF_W-1 -: 4], hw[2*HALF_W-1 -: 4]};
      endcase
      return c;
   endfunction

   // Raw copy used by legacy mode: halfword idx, low twelve bits
   function automatic logic [FIELD_W-1:0] raw_code(input logic [FUSE_W-1:0] hw,
                                                    input logic [1:0] idx);
      logic [FIELD_W-1:0] c;
      case (idx)
         2'd0:    c = hw[0*HALF_W +: FIELD_W];
         2'd1:    c = hw[1*HALF_W +: FIELD_W];
         2'd2:    c = hw[2*HALF_W +: FIELD_W];
         default: c = hw[3*HALF_W +: FIELD_W];
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fcg_divider.sv
module fcg_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  dvs_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    shifted;
   logic          take;

   initial begin
      if (W < 8) $error("fcg_divider: W too small");
   end

   assign shifted  = {rem_q, quo_q[W-1]};
   assign take     = shifted >= {1'b0, dvs_q};
   assign quotient = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (take) rem_q <= W'(shifted - {1'b0, dvs_q});
            else      rem_q <= shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fcg_regbank.sv
module fcg_regbank #(
   parameter int SENSORS = 4,
   parameter int NREG    = (SENSORS + 1) / 2,
   parameter int IW      = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IW-1:0]        wr_index,
   input  logic [31:0]          wr_data,
   input  logic [3:0]           wr_be,
   output logic [NREG*32-1:0]   regs_flat
);
   import fcg_pkg::*;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [15:0] LO_RST = (2*r     < SENSORS) ? 16'(MID_CODE) : 16'h0;
      localparam logic [15:0] HI_RST = (2*r + 1 < SENSORS) ? 16'(MID_CODE) : 16'h0;
      localparam logic [31:0] RST    = {HI_RST, LO_RST};
      logic sel;
      assign sel = wr_en && (wr_index == IW'(r));
      for (genvar b = 0; b < 4; b++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                regs_flat[r*32 + b*8 +: 8] <= RST[b*8 +: 8];
            else if (sel && wr_be[b])  regs_flat[r*32 + b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/fcg_seq.sv
module fcg_seq #(
   parameter int SENSORS  = 4,
   parameter int T_OFFSET = 187744,
   parameter int T_SCALE  = 672,
   parameter int DIV_W    = 32,
   parameter int NREG     = (SENSORS + 1) / 2,
   parameter int IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      legacy_mode,
   input  logic [fcg_pkg::FUSE_W-1:0] fuse_words,
   input  logic [7:0]                fuse_bytes,
   output logic                      div_go,
   output logic [DIV_W-1:0]          div_dividend,
   output logic [DIV_W-1:0]          div_divisor,
   input  logic                      div_done,
   input  logic [DIV_W-1:0]          div_quot,
   output logic                      busy,
   output logic                      done,
   output logic                      abort_err,
   output logic                      wr_en,
   output logic [IW-1:0]             wr_index,
   output logic [31:0]               wr_data,
   output logic [3:0]                wr_be,
   output logic [SENSORS-1:0]        sensor_ok,
   output logic [SENSORS-1:0]        sensor_skip
);
   import fcg_pkg::*;

   localparam logic [1:0] LAST_IDX  = 2'(SENSORS - 1);
   localparam logic [7:0] MIN_BYTES = 8'(2 * SENSORS);

   fcg_state_e               state_q;
   logic [1:0]               idx_q;
   logic [FUSE_W-1:0]        hw_q;
   logic                     leg_q;
   logic [7:0]               bytes_q;
   logic signed [DIV_W-1:0]  ft_q;
   logic                     neg_q;
   logic signed [DIV_W-1:0]  cal_q;

   logic signed [DIV_W-1:0]  st_c;
   logic signed [DIV_W-1:0]  delta_c;
   logic [DIV_W-1:0]         mag_c;
   logic signed [DIV_W-1:0]  cal_c;
   logic                     fits;
   logic [FIELD_W-1:0]       field_c;
   logic [FIELD_W-1:0]       code_c;
   logic                     bad_hdr;

   assign code_c  = sensor_code(hw_q, idx_q);
   assign bad_hdr = (hw_q[HALF_W-1:0] == '0) || (leg_q && (bytes_q < MIN_BYTES));

   always_comb begin
      st_c    = DIV_W'(T_OFFSET) - $signed(div_quot);
      delta_c = st_c - ft_q;
      mag_c   = delta_c[DIV_W-1] ? DIV_W'(-delta_c) : DIV_W'(delta_c);
      cal_c   = neg_q ? (DIV_W'(MID_CODE) + $signed(div_quot))
                      : (DIV_W'(MID_CODE) - $signed(div_quot));
      fits    = (cal_q[DIV_W-1:FIELD_W] == '0);
   end

   // divider issue: first the model division, then the correction division
   always_comb begin
      div_go       = (state_q == ST_FETCH) || ((state_q == ST_DIV_T) && div_done);
      div_dividend = (state_q == ST_FETCH) ? DIV_W'(code_c) * DIV_W'(T_SCALE)
                                           : mag_c * DIV_W'(10);
      div_divisor  = (state_q == ST_FETCH) ? DIV_W'(10) : DIV_W'(T_SCALE);
   end

   // write port
   always_comb begin
      field_c  = (state_q == ST_LEGACY) ? raw_code(hw_q, idx_q) : cal_q[FIELD_W-1:0];
      wr_en    = (state_q == ST_LEGACY) || ((state_q == ST_WRITE) && fits);
      wr_index = IW'(idx_q >> 1);
      if (idx_q[0]) begin
         wr_data = {4'h0, field_c, 16'h0};
         wr_be   = 4'b1100;
      end else begin
         wr_data = {20'h0, field_c};
         wr_be   = 4'b0011;
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         idx_q       <= '0;
         hw_q        <= '0;
         leg_q       <= 1'b0;
         bytes_q     <= '0;
         ft_q        <= '0;
         neg_q       <= 1'b0;
         cal_q       <= '0;
         abort_err   <= 1'b0;
         sensor_ok   <= '0;
         sensor_skip <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               hw_q        <= fuse_words;
               leg_q       <= legacy_mode;
               bytes_q     <= fuse_bytes;
               idx_q       <= '0;
               abort_err   <= 1'b0;
               sensor_ok   <= '0;
               sensor_skip <= '0;
               state_q     <= ST_CHECK;
            end
            ST_CHECK: begin
               ft_q <= $signed(DIV_W'(hw_q[FIELD_W-1:0]) * DIV_W'(100));
               if (bad_hdr) begin
                  abort_err <= 1'b1;
                  state_q   <= ST_FIN;
               end else if (leg_q) begin
                  state_q   <= ST_LEGACY;
               end else begin
                  state_q   <= ST_FETCH;
               end
            end
            ST_LEGACY: begin
               sensor_ok[idx_q] <= 1'b1;
               if (idx_q == LAST_IDX) state_q <= ST_FIN;
               else                   idx_q   <= idx_q + 1'b1;
            end
            ST_FETCH: state_q <= ST_DIV_T;
            ST_DIV_T: if (div_done) begin
               neg_q   <= delta_c[DIV_W-1];
               state_q <= ST_DIV_C;
            end
            ST_DIV_C: if (div_done) begin
               cal_q   <= cal_c;
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (fits) sensor_ok[idx_q]   <= 1'b1;
               else      sensor_skip[idx_q] <= 1'b1;
               if (idx_q == LAST_IDX) state_q <= ST_FIN;
               else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fuse_cal_gen.sv
module fuse_cal_gen #(
   parameter int SENSORS  = 4,
   parameter int T_OFFSET = 187744,
   parameter int T_SCALE  = 672,
   parameter int DIV_W    = 32,
   parameter int NREG     = (SENSORS + 1) / 2,
   parameter int WR_IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    legacy_mode,
   input  logic [63:0]             fuse_words,
   input  logic [7:0]              fuse_bytes,
   output logic                    busy,
   output logic                    done,
   output logic                    abort_err,
   output logic                    wr_en,
   output logic [WR_IDX_W-1:0]     wr_index,
   output logic [31:0]             wr_data,
   output logic [3:0]              wr_be,
   output logic [NREG*32-1:0]      cal_regs,
   output logic [SENSORS-1:0]      sensor_ok,
   output logic [SENSORS-1:0]      sensor_skip
);
   if (SENSORS < 1 || SENSORS > 4) begin : g_bad_count
      $error("fuse_cal_gen: SENSORS must be 1..4");
   end
   if (T_SCALE < 1 || T_SCALE > 65535) begin : g_bad_scale
      $error("fuse_cal_gen: T_SCALE out of range");
   end
   if (DIV_W < 32) begin : g_bad_width
      $error("fuse_cal_gen: DIV_W must be at least 32");
   end

   logic             div_go;
   logic             div_done;
   logic [DIV_W-1:0] div_dividend;
   logic [DIV_W-1:0] div_divisor;
   logic [DIV_W-1:0] div_quot;

   fcg_seq #(
      .SENSORS (SENSORS),
      .T_OFFSET(T_OFFSET),
      .T_SCALE (T_SCALE),
      .DIV_W   (DIV_W),
      .NREG    (NREG),
      .IW      (WR_IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .legacy_mode (legacy_mode),
      .fuse_words  (fuse_words),
      .fuse_bytes  (fuse_bytes),
      .div_go      (div_go),
      .div_dividend(div_dividend),
      .div_divisor (div_divisor),
      .div_done    (div_done),
      .div_quot    (div_quot),
      .busy        (busy),
      .done        (done),
      .abort_err   (abort_err),
      .wr_en       (wr_en),
      .wr_index    (wr_index),
      .wr_data     (wr_data),
      .wr_be       (wr_be),
      .sensor_ok   (sensor_ok),
      .sensor_skip (sensor_skip)
   );

   fcg_divider #(.W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (div_go),
      .dividend(div_dividend),
      .divisor (div_divisor),
      .done    (div_done),
      .quotient(div_quot)
   );

   fcg_regbank #(
      .SENSORS(SENSORS),
      .NREG   (NREG),
      .IW     (WR_IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_index (wr_index),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .regs_flat(cal_regs)
   );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
   parameter int SENSORS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               abort_err,
   input logic               wr_en,
   input logic [31:0]        wr_data,
   input logic [3:0]         wr_be,
   input logic [SENSORS-1:0] sensor_ok,
   input logic [SENSORS-1:0] sensor_skip
);
   assert_field_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_be == 4'b0011 && wr_data[31:12] == '0) ||
                 (wr_be == 4'b1100 && wr_data[31:28] == '0 && wr_data[15:0] == '0)));

   assert_write_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (busy && !done));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_abort_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_err |-> !wr_en);

   assert_status_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sensor_ok & sensor_skip) == '0);

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_status_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((sensor_ok | sensor_skip) == '0 && !abort_err));
endmodule

bind fuse_cal_gen fcg_checker #(.SENSORS(SENSORS)) u_fcg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .abort_err  (abort_err),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .wr_be      (wr_be),
   .sensor_ok  (sensor_ok),
   .sensor_skip(sensor_skip)
);

// File: tb/fuse_cal_gen_test.sv
module fuse_cal_gen_test;
   localparam int S    = 4;
   localparam int OFF  = 187744;
   localparam int SC   = 672;
   localparam int NR   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          legacy_mode = 1'b0;
   logic [63:0]   fuse_words = '0;
   logic [7:0]    fuse_bytes = '0;
   logic          busy, done, abort_err, wr_en;
   logic [0:0]    wr_index;
   logic [31:0]   wr_data;
   logic [3:0]    wr_be;
   logic [NR*32-1:0] cal_regs;
   logic [S-1:0]  sensor_ok, sensor_skip;

   int checks = 0;
   int fails  = 0;
   int model [S];
   int wr_seq [16];
   int wr_cnt = 0;

   always #10 clk = ~clk;

   fuse_cal_gen #(.SENSORS(S), .T_OFFSET(OFF), .T_SCALE(SC)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .legacy_mode(legacy_mode),
      .fuse_words(fuse_words), .fuse_bytes(fuse_bytes), .busy(busy), .done(done),
      .abort_err(abort_err), .wr_en(wr_en), .wr_index(wr_index), .wr_data(wr_data),
      .wr_be(wr_be), .cal_regs(cal_regs), .sensor_ok(sensor_ok), .sensor_skip(sensor_skip)
   );

   always @(negedge clk) begin
      if (wr_en && wr_cnt < 16) begin
         wr_seq[wr_cnt] = int'(wr_index) * 2 + ((wr_be == 4'b1100) ? 1 : 0);
         wr_cnt = wr_cnt + 1;
      end
   end

   initial begin
      #(20 * 150000);
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual busy=%0d expected 0", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int field_of(input int i);
      logic [31:0] r;
      r = cal_regs[(i/2)*32 +: 32];
      return (i % 2 == 1) ? int'(r[27:16]) : int'(r[11:0]);
   endfunction

   function automatic int code_of(input logic [63:0] hw, input int i);
      if (i < 3) return int'(hw[(i+1)*16 +: 12]);
      return int'({hw[63:60], hw[47:44], hw[31:28]});
   endfunction

   function automatic int cal_of(input logic [63:0] hw, input int i);
      int ft, st, d;
      ft = int'(hw[11:0]) * 100;
      st = OFF - (code_of(hw, i) * SC) / 10;
      d  = st - ft;
      return 2048 - (d * 10) / SC;
   endfunction

   task automatic pulse_start(input logic [63:0] hw, input bit leg, input int nb);
      fuse_words  = hw;
      legacy_mode = leg;
      fuse_bytes  = 8'(nb);
      start       = 1'b1;
      @(negedge clk);
      start       = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   // Checks a finished run against the model built from hw/leg/nb
   task automatic judge(input logic [63:0] hw, input bit leg, input int nb, input string tag);
      bit abort_exp;
      int nexp, last;
      abort_exp = (hw[15:0] == 16'h0) || (leg && nb < 2*S);
      chk(abort_err == abort_exp, abort_exp ? "R6" : "R7", {tag, " abort flag"}, int'(abort_err), int'(abort_exp));
      nexp = 0;
      for (int i = 0; i < S; i++) begin
         int want; bit okx;
         okx = 1'b0;
         if (!abort_exp) begin
            want = leg ? int'(hw[i*16 +: 12]) : cal_of(hw, i);
            okx  = (want >= 0 && want <= 4095);
            if (okx) begin model[i] = want; nexp++; end
         end
         chk(field_of(i) == model[i], leg ? "R7" : (okx ? "R3" : "R4"), {tag, " field"}, field_of(i), model[i]);
         chk(sensor_ok[i] == okx, "R4", {tag, " ok bit"}, int'(sensor_ok[i]), int'(okx));
         chk(sensor_skip[i] == (!abort_exp && !okx), "R4", {tag, " skip bit"},
             int'(sensor_skip[i]), int'(!abort_exp && !okx));
      end
      chk(wr_cnt == nexp, "R8", {tag, " write count"}, wr_cnt, nexp);
      last = -1;
      for (int w = 0; w < wr_cnt && w < 16; w++) begin
         chk(wr_seq[w] > last, "R8", {tag, " write order"}, wr_seq[w], last + 1);
         last = wr_seq[w];
      end
   endtask

   task automatic run_case(input logic [63:0] hw, input bit leg, input int nb, input string tag);
      bit seen;
      wr_cnt = 0;
      pulse_start(hw, leg, nb);
      wait_done(seen);
      chk(seen, "R8", {tag, " done seen"}, int'(seen), 1);
      chk(busy == 1'b1, "R8", {tag, " busy at done"}, int'(busy), 1);
      judge(hw, leg, nb, tag);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " done one cycle"}, int'(done), 0);
   endtask

   initial begin
      logic [63:0] hw;
      bit seen;
      void'($urandom(32'h1d2c3b4a));
      for (int i = 0; i < S; i++) model[i] = 2048;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < S; i++)
         chk(field_of(i) == 2048, "R1", "reset field", field_of(i), 2048);
      chk(cal_regs[15:12] == 0 && cal_regs[31:28] == 0, "R1", "reset spare bits", int'(cal_regs[31:28]), 0);
      chk({busy, done, abort_err} == 3'b000, "R1", "reset flags", int'({busy, done, abort_err}), 0);
      chk(sensor_ok == 0 && sensor_skip == 0, "R1", "reset status", int'(sensor_ok), 0);

      // near-centre calibration: 25.0 C factory, codes close to the model point
      hw = {4'h1, 12'd2410, 4'h9, 12'd2421, 4'h8, 12'd2400, 16'd250};
      run_case(hw, 1'b0, 8, "R2 nominal");

      // sensor 3 nibble gather with all distinct nibbles
      hw = {4'h9, 12'd2300, 4'h5, 12'd2500, 4'h3, 12'd2421, 16'd300};
      run_case(hw, 1'b0, 8, "R2 nibbles");

      // overflow: hot factory reading pushes sensors past 12 bits
      hw = {4'h0, 12'd0, 4'h0, 12'd2421, 4'h0, 12'd0, 16'd4000};
      run_case(hw, 1'b0, 8, "R4 overflow");

      // zero halfword 0 aborts
      hw = {16'hffff, 16'h1234, 16'h0abc, 16'h0000};
      run_case(hw, 1'b0, 8, "R6 zero header");

      // legacy copy and legacy short length
      hw = {16'hf123, 16'h8456, 16'h4789, 16'h20ab};
      run_case(hw, 1'b1, 8, "R7 legacy");
      hw = {16'h0111, 16'h0222, 16'h0333, 16'h0444};
      run_case(hw, 1'b1, 7, "R7 legacy short");

      // R9: start while busy with other data is ignored
      hw = {4'h2, 12'd2420, 4'h2, 12'd2430, 4'h2, 12'd2410, 16'd260};
      wr_cnt = 0;
      pulse_start(hw, 1'b0, 8);
      repeat (3) @(negedge clk);
      pulse_start(64'h0fff_0fff_0fff_0001, 1'b1, 8);
      wait_done(seen);
      chk(seen, "R9", "mid-run done", int'(seen), 1);
      judge(hw, 1'b0, 8, "R9 mid-run");

      // R9: start in the done cycle is ignored
      fuse_words = 64'h0aaa_0bbb_0ccc_0001;
      legacy_mode = 1'b1;
      fuse_bytes = 8'd8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wr_cnt = 0;
      repeat (6) @(negedge clk);
      chk(busy == 1'b0, "R9", "start at done busy", int'(busy), 0);
      chk(wr_cnt == 0, "R9", "start at done writes", wr_cnt, 0);
      for (int i = 0; i < S; i++)
         chk(field_of(i) == model[i], "R9", "start at done field", field_of(i), model[i]);

      // constrained random mix
      for (int n = 0; n < 30; n++) begin
         logic [63:0] r;
         bit leg;
         int nb;
         r = {$urandom, $urandom};
         if ($urandom_range(9) < 6) begin
            r[11:0] = 12'($urandom_range(150, 450));
            for (int i = 1; i < 4; i++) r[i*16 +: 12] = 12'($urandom_range(1900, 2900));
         end
         if ($urandom_range(15) == 0) r[15:0] = 16'h0;
         leg = ($urandom_range(4) == 0);
         nb  = $urandom_range(4, 12);
         run_case(r, leg, nb, "R3 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule